// File: doc/BRIEF.md
# Directional Two-Port Mailbox Memory

This block is a shared byte store that two processors use to pass messages to each other. It holds two separate areas of 128 bytes each. Each area has exactly one writer and one reader. Port A fills the outbound area and port B drains it. Port B fills the return area and port A drains it. Each port has its own address, active-low select, write and output-enable strobes, and its own data-in and data-out buses. Both ports share one clock but otherwise run on their own.

Address bit 7 picks the area and bits 6..0 pick the byte within it. A port that uses bit 7 in the direction it does not own has no effect on storage. The port's error flag reports such an access for one cycle. A read is registered, so its data appears one cycle after the request. An output-drive flag stands in for a three-state pin. A read of a byte that the other port writes in the same cycle returns the byte being written.

The ports are plain strobed memory ports and not streams. There is no valid/ready handshake, and either port can issue an access on every cycle without ever being held back.

Top module: `dp_mailbox`

## Requirements
- R1: Address bit 7 selects the area: 0 is the outbound area (written by A, read by B) and 1 is the return area (written by B, read by A). Bits 6..0 select one of 128 bytes inside the area.
- R2: When `a_cs_n`=0, `a_we_n`=0 and `a_addr[7]`=0 at a rising edge, `a_wdata` is stored at outbound byte `a_addr[6:0]`. Port B can later read that byte using address bit 7 = 0.
- R3: When `b_cs_n`=0, `b_we_n`=0 and `b_addr[7]`=1 at a rising edge, `b_wdata` is stored at return byte `b_addr[6:0]`. Port A can later read that byte using address bit 7 = 1.
- R4: A write with the wrong bit 7 (A with bit 7 = 1, B with bit 7 = 0) leaves both areas unchanged. The port's `bad` flag is then 1 for the cycle after that edge.
- R5: A read with the wrong bit 7 (A with bit 7 = 0, B with bit 7 = 1) gives `drive`=1, `rdata`=0 and `bad`=1 in the cycle after the edge.
- R6: A read request is `cs_n`=0, `we_n`=1 and `oe_n`=0 at a rising edge. After that edge the port shows `drive`=1 and the addressed byte on `rdata` for one cycle.
- R7: While `cs_n`=1 the port neither writes nor reads. After the edge its `drive`, `bad` and `rdata` are all 0.
- R8: While `oe_n`=1 the port output is not driven after the edge, even during a write. A read request with `oe_n`=1 raises no `bad` flag.
- R9: When one port reads a byte that the other port writes in the same cycle, the read returns the new byte.
- R10: During and just after reset, `drive`, `bad` and `rdata` are 0 on both ports. Reset does not clear the stored bytes.
- R11: Whenever `drive` is 0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset of the output stages |
| a_addr | input | 8 | Port A address; bit 7 selects the area |
| a_cs_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_wdata | input | 8 | Port A write byte |
| a_rdata | output | 8 | Port A read byte, zero when not driven |
| a_drive | output | 1 | Port A output drive (stands in for the three-state enable) |
| a_bad | output | 1 | Port A wrong-direction access, one cycle |
| b_addr | input | 8 | Port B address; bit 7 selects the area |
| b_cs_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_wdata | input | 8 | Port B write byte |
| b_rdata | output | 8 | Port B read byte, zero when not driven |
| b_drive | output | 1 | Port B output drive |
| b_bad | output | 1 | Port B wrong-direction access, one cycle |

## Verification
The assertions check several rules on every cycle:
- a read request is followed by a driven output;
- a deselected port or a high output enable gives an undriven output;
- a wrong-direction read returns zero data;
- a legal write lands in storage;
- a colliding read returns the byte being written.

Only the bench's scenarios can show the rest:
- that a byte written by one port comes back at the other port at the right address across every location of both areas;
- that wrong-direction and deselected writes leave the stored contents intact;
- that a reset keeps the stored bytes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_ADDR_W = 8;
  localparam int unsigned MBX_DATA_W = 8;

  // area code carried by address bit 7
  typedef enum logic {
    AREA_OUT = 1'b0,
    AREA_RET = 1'b1
  } area_e;
endpackage

// File: rtl/mbx_area.sv
module mbx_area #(
  parameter int unsigned WORD_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << WORD_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              hit;

  assign hit = wr_en && (waddr == raddr);

  // storage is not reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= hit ? wdata : mem[raddr];
  end

  assign rdata = rdata_q;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> mem[$past(waddr)] == $past(wdata));

  assert_collision_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(rd_en) && $past(waddr) == $past(raddr))
      |-> rdata == $past(wdata));
endmodule

// File: rtl/mbx_port_ctrl.sv
module mbx_port_ctrl #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter bit          WR_AREA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  output logic              wr_en,
  output logic              rd_en,
  output logic [ADDR_W-2:0] word,
  input  logic [DATA_W-1:0] area_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              drive,
  output logic              bad
);
  logic wr_try, rd_try, own_area, bad_now;
  logic drive_q, bad_q, good_q;

  assign word     = addr[ADDR_W-2:0];
  assign own_area = (addr[ADDR_W-1] == WR_AREA);
  assign wr_try   = !cs_n && !we_n;
  assign rd_try   = !cs_n && we_n && !oe_n;
  assign wr_en    = wr_try && own_area;
  assign rd_en    = rd_try && !own_area;
  assign bad_now  = (wr_try && !own_area) || (rd_try && own_area);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      bad_q   <= 1'b0;
      good_q  <= 1'b0;
    end else begin
      drive_q <= rd_try;
      bad_q   <= bad_now;
      good_q  <= rd_en;
    end
  end

  assign drive = drive_q;
  assign bad   = bad_q;
  assign rdata = good_q ? area_rdata : '0;

  assert_read_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n) |=> drive);

  assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!drive && !bad && rdata == '0));

  assert_oe_high_undriven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !drive);

  assert_bad_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n && own_area) |=> (bad && rdata == '0));

  assert_undriven_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> rdata == '0);
endmodule

// File: rtl/dp_mailbox.sv
module dp_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = MBX_ADDR_W,
  parameter int unsigned DATA_W = MBX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_drive,
  output logic              a_bad,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_drive,
  output logic              b_bad
);
  localparam int unsigned WORD_W = ADDR_W - 1;

  logic              a_wr, a_rd, b_wr, b_rd;
  logic [WORD_W-1:0] a_word, b_word;
  logic [DATA_W-1:0] out_rdata, ret_rdata;

  // port A owns writes to the outbound area, port B owns writes to the return area
  mbx_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_AREA(AREA_OUT)) u_ctl_a (
    .clk(clk), .rst_n(rst_n), .addr(a_addr), .cs_n(a_cs_n), .we_n(a_we_n),
    .oe_n(a_oe_n), .wr_en(a_wr), .rd_en(a_rd), .word(a_word),
    .area_rdata(ret_rdata), .rdata(a_rdata), .drive(a_drive), .bad(a_bad));

  mbx_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_AREA(AREA_RET)) u_ctl_b (
    .clk(clk), .rst_n(rst_n), .addr(b_addr), .cs_n(b_cs_n), .we_n(b_we_n),
    .oe_n(b_oe_n), .wr_en(b_wr), .rd_en(b_rd), .word(b_word),
    .area_rdata(out_rdata), .rdata(b_rdata), .drive(b_drive), .bad(b_bad));

  mbx_area #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_area_out (
    .clk(clk), .rst_n(rst_n), .wr_en(a_wr), .waddr(a_word), .wdata(a_wdata),
    .rd_en(b_rd), .raddr(b_word), .rdata(out_rdata));

  mbx_area #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_area_ret (
    .clk(clk), .rst_n(rst_n), .wr_en(b_wr), .waddr(b_word), .wdata(b_wdata),
    .rd_en(a_rd), .raddr(a_word), .rdata(ret_rdata));

  assert_one_writer_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr |-> b_addr[ADDR_W-1]);
  assert_one_writer_ret_R1: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |-> !a_addr[ADDR_W-1]);
endmodule

// File: tb/dp_mailbox_test.sv
module dp_mailbox_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a_addr = '0, b_addr = '0, a_wdata = '0, b_wdata = '0;
  logic       a_cs_n = 1'b1, a_we_n = 1'b1, a_oe_n = 1'b1;
  logic       b_cs_n = 1'b1, b_we_n = 1'b1, b_oe_n = 1'b1;
  logic [7:0] a_rdata, b_rdata;
  logic       a_drive, a_bad, b_drive, b_bad;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_out [128];
  logic [7:0] m_ret [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drive(a_drive), .a_bad(a_bad),
    .b_addr(b_addr), .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drive(b_drive), .b_bad(b_bad));

  function automatic logic [7:0] pat_a(int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] pat_b(int i); return 8'(i * 11) ^ 8'h5A; endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    a_cs_n = 1; a_we_n = 1; a_oe_n = 1;
    b_cs_n = 1; b_we_n = 1; b_oe_n = 1;
  endtask

  task automatic rd_a(logic [7:0] ad); a_addr = ad; a_cs_n = 0; a_we_n = 1; a_oe_n = 0; endtask
  task automatic rd_b(logic [7:0] ad); b_addr = ad; b_cs_n = 0; b_we_n = 1; b_oe_n = 0; endtask
  task automatic wr_a(logic [7:0] ad, logic [7:0] d, logic oe);
    a_addr = ad; a_wdata = d; a_cs_n = 0; a_we_n = 0; a_oe_n = oe;
  endtask
  task automatic wr_b(logic [7:0] ad, logic [7:0] d, logic oe);
    b_addr = ad; b_wdata = d; b_cs_n = 0; b_we_n = 0; b_oe_n = oe;
  endtask

  // read both areas at a word and compare with the model
  task automatic read_back(int i, string req);
    rd_a({1'b1, 7'(i)}); rd_b({1'b0, 7'(i)});
    step();
    chk(req, a_rdata, m_ret[i]);
    chk(req, b_rdata, m_out[i]);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    step(); step();
    // R10 reset state
    chk("R10", {a_drive, a_bad, b_drive, b_bad}, 8'h0);
    chk("R10", a_rdata, 8'h0);
    chk("R10", b_rdata, 8'h0);
    rst_n = 1;
    step();

    // R2 R3 R8: fill both areas together; writes never drive, oe toggled
    for (int i = 0; i < 128; i++) begin
      wr_a({1'b0, 7'(i)}, pat_a(i), 1'(i & 1));
      wr_b({1'b1, 7'(i)}, pat_b(i), 1'((i >> 1) & 1));
      m_out[i] = pat_a(i); m_ret[i] = pat_b(i);
      step();
      chk("R8 write undriven", {a_drive, b_drive, a_bad, b_bad}, 8'h0);
    end
    idle();

    // R1 R2 R3 R6: cross reads of every word
    for (int i = 0; i < 128; i++) begin
      rd_a({1'b1, 7'(i)}); rd_b({1'b0, 7'(i)});
      step();
      chk("R3 A reads return area", a_rdata, pat_b(i));
      chk("R2 B reads outbound area", b_rdata, pat_a(i));
      chk("R6 drive", {a_drive, b_drive, a_bad, b_bad}, 8'b1100);
    end
    idle();
    step();
    chk("R6 one cycle", {a_drive, b_drive}, 8'h0);
    chk("R11", a_rdata | b_rdata, 8'h0);

    // R4 wrong-direction writes
    for (int i = 0; i < 128; i += 9) begin
      wr_a({1'b1, 7'(i)}, ~pat_b(i), 1'b0);
      wr_b({1'b0, 7'(i)}, ~pat_a(i), 1'b0);
      step();
      chk("R4 bad flag", {a_bad, b_bad, a_drive, b_drive}, 8'b1100);
      idle();
      step();
      chk("R4 flag one cycle", {a_bad, b_bad}, 8'h0);
      read_back(i, "R4 unchanged");
    end

    // R5 wrong-direction reads
    for (int i = 3; i < 128; i += 17) begin
      rd_a({1'b0, 7'(i)}); rd_b({1'b1, 7'(i)});
      step();
      chk("R5 flags", {a_drive, a_bad, b_drive, b_bad}, 8'b1111);
      chk("R5 zero data", a_rdata | b_rdata, 8'h0);
      idle();
    end

    // R7 deselected writes and reads
    for (int i = 1; i < 128; i += 31) begin
      wr_a({1'b0, 7'(i)}, 8'hEE, 1'b0); wr_b({1'b1, 7'(i)}, 8'hDD, 1'b0);
      a_cs_n = 1; b_cs_n = 1;
      step();
      chk("R7 quiet", {a_drive, a_bad, b_drive, b_bad}, 8'h0);
      chk("R7 zero data", a_rdata | b_rdata, 8'h0);
      rd_a({1'b1, 7'(i)}); rd_b({1'b0, 7'(i)});
      a_cs_n = 1; b_cs_n = 1;
      step();
      chk("R7 no read", {a_drive, b_drive}, 8'h0);
      idle();
      read_back(i, "R7 unchanged");
    end

    // R8 read request with output enable high
    rd_a(8'h80); rd_b(8'h00); a_oe_n = 1; b_oe_n = 1;
    step();
    chk("R8 oe high", {a_drive, a_bad, b_drive, b_bad}, 8'h0);
    chk("R11 oe high", a_rdata | b_rdata, 8'h0);
    idle();

    // R9 collisions in both areas
    wr_a(8'h05, 8'hC3, 1'b1); rd_b(8'h05); m_out[5] = 8'hC3;
    step();
    chk("R9 B sees new", b_rdata, 8'hC3);
    idle();
    wr_b(8'h89, 8'h3C, 1'b1); rd_a(8'h89); m_ret[9] = 8'h3C;
    step();
    chk("R9 A sees new", a_rdata, 8'h3C);
    idle();
    read_back(5, "R9 stored");
    read_back(9, "R9 stored");

    // R10 reset mid-run keeps contents
    rd_a(8'h89); rd_b(8'h05);
    rst_n = 0;
    step();
    chk("R10 in reset", {a_drive, a_bad, b_drive, b_bad}, 8'h0);
    chk("R10 in reset", a_rdata | b_rdata, 8'h0);
    idle();
    step();
    rst_n = 1;
    step();
    chk("R10 after reset", {a_drive, b_drive}, 8'h0);
    read_back(5, "R10 kept");
    read_back(9, "R10 kept");
    read_back(127, "R1 top word");
    read_back(0, "R1 bottom word");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule